// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This unit holds six 32-bit up-counters that tally processor events for profiling. Each counter has its own 32-bit vector of per-cycle event inputs. A five-bit select field picks one line of that vector. Select code 0 picks nothing, so that counter holds its value. Counting can be stopped in several ways:

- globally, by one freeze bit;
- by privilege level, for supervisor or user code;
- by the level of a process mark input, when it is 1 or when it is 0.

Software preloads a counter with `0x80000000 - N` so that the counter enters its condition state, with bit 31 set, after N counted events. An enabled condition can raise a level interrupt. It can also freeze every counter in hardware until software clears the global freeze bit.

Software reaches the unit through a flat register port:

| Address | Register |
|---|---|
| 0 | main control register |
| 1 | select register for the upper four counters |
| 2 | spare control register, storage only |
| 3 to 8 | counters 1 to 6 |

A write takes effect on the next clock edge. Reads are combinational.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset the main control register (address 0) reads 0xF800_0000. Addresses 1 and 2, all six counters and `irq_o` read 0.
- R2: A write to addresses 0 to 8 takes effect at the next rising edge and reads back at once. Address 2 is plain storage with no effect on counting. Writes to addresses 9 to 15 are ignored, and those addresses read 0. Address 0 keeps only bits 31:23, 10:6 and 4:0 of a written value.
- R3: A counter that is not frozen adds exactly 1 on each edge where the event line picked by its select value is high. A select value of 0 keeps the counter unchanged whatever its event inputs do.
- R4: The select fields sit at fixed positions:

  | Counter | Register | Bits |
  |---|---|---|
  | 1 | address 0 | 10:6 |
  | 2 | address 0 | 4:0 |
  | 3 | address 1 | 31:27 |
  | 4 | address 1 | 26:22 |
  | 5 | address 1 | 21:17 |
  | 6 | address 1 | 15:11 |

  Counter k (k = 1..6) takes its events from `ev_i[(k-1)*32 +: 32]`.
- R5: Freeze bits in address 0 stop all counters while their case holds:

  | Bit | Freezes when |
  |---|---|
  | 31 | always |
  | 30 | `priv_i`=1 |
  | 29 | `priv_i`=0 |
  | 28 | `mark_i`=1 |
  | 27 | `mark_i`=0 |

- R6: A counter is in its condition state when its bit 31 is 1. Bit 24 of address 0 enables the condition of counter 1, and bit 23 enables the conditions of counters 2 to 6. `irq_o` = bit 25 AND (any enabled condition). It stays high until the condition is rewritten away or disabled.
- R7: When bit 26 of address 0 is 1 and an enabled condition exists, no counter increments from that cycle on. On the next edge bit 31 of address 0 becomes 1, unless address 0 is being written in that cycle.
- R8: A write to a counter in the same cycle as a qualifying event loads the written value; the increment is lost.
- R9: A counter at 0xFFFF_FFFF that counts one event wraps to 0, and its condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| ev_i | input | 192 | Per-cycle event lines, 32 per counter |
| priv_i | input | 1 | 1 = supervisor state, 0 = user state |
| mark_i | input | 1 | Process mark bit |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is the hardware freeze of R7. It needs one counter to cross into bit 31 while a second counter is still counting, and the global freeze bit must be set by the unit itself rather than by a write. The bench preloads counter 1 two events short of the boundary and leaves counter 2 at zero. It then holds both event lines high for five cycles. Afterwards it checks three things: both counters stopped on the cycle of the crossing, counter 2 reads exactly 2, and address 0 reads back with bit 31 set.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int REG_W   = 32;
    localparam int SEL_W   = 5;
    localparam int EV_N    = 1 << SEL_W;
    localparam int ADDR_W  = 4;
    localparam int MAX_CTR = 6;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTL0 = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTL1 = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTL2 = 4'd2;
    localparam int                A_CNT0 = 3;

    // main control register layout, most significant bit first
    typedef struct packed {
        logic             freeze_all;   // 31
        logic             frz_super;    // 30
        logic             frz_user;     // 29
        logic             frz_mark1;    // 28
        logic             frz_mark0;    // 27
        logic             frz_on_cond;  // 26
        logic             irq_en;       // 25
        logic             cond_en_first;// 24
        logic             cond_en_rest; // 23
        logic [11:0]      rsvd_hi;      // 22:11
        logic [SEL_W-1:0] sel_a;        // 10:6, counter 1
        logic             rsvd_lo;      // 5
        logic [SEL_W-1:0] sel_b;        // 4:0, counter 2
    } ctl0_t;

    localparam logic [REG_W-1:0] CTL0_RST  = 32'hF800_0000;
    localparam logic [REG_W-1:0] CTL0_MASK = 32'hFF80_07DF;

    // select code of counter idx (0-based)
    function automatic logic [SEL_W-1:0] sel_of(input int idx,
                                                 input logic [REG_W-1:0] c0,
                                                 input logic [REG_W-1:0] c1);
        case (idx)
            0:       return c0[10:6];
            1:       return c0[4:0];
            2:       return c1[31:27];
            3:       return c1[26:22];
            4:       return c1[21:17];
            default: return c1[15:11];
        endcase
    endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_i,
    input  logic [REG_W-1:0] ld_val_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [EV_N-1:0]  ev_i,
    input  logic             frz_i,
    output logic [REG_W-1:0] val_o
);

    logic inc;

    always_comb begin
        inc = (sel_i != '0) && ev_i[sel_i] && !frz_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_o <= '0;
        end else if (ld_i) begin
            val_o <= ld_val_i;
        end else if (inc) begin
            val_o <= val_o + REG_W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !ld_i |=> (val_o == $past(val_o) || val_o == $past(val_o) + REG_W'(1))); // R3

    AST_SEL0_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld_i && sel_i == '0) |=> $stable(val_o)); // R3

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld_i && frz_i) |=> $stable(val_o)); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> val_o == $past(ld_val_i)); // R8

endmodule

// File: rtl/pmu_gate.sv
module pmu_gate
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 6
) (
    input  logic [NUM_CTR-1:0] cond_i,
    input  logic               freeze_all_i,
    input  logic               frz_super_i,
    input  logic               frz_user_i,
    input  logic               frz_mark1_i,
    input  logic               frz_mark0_i,
    input  logic               frz_on_cond_i,
    input  logic               irq_en_i,
    input  logic               ce_first_i,
    input  logic               ce_rest_i,
    input  logic               priv_i,
    input  logic               mark_i,
    output logic               freeze_o,
    output logic               hw_frz_o,
    output logic               irq_o
);

    logic en_hit;
    logic rest_any;
    logic soft_frz;

    always_comb begin
        rest_any = |(cond_i >> 1);
        en_hit   = (cond_i[0] && ce_first_i) || (rest_any && ce_rest_i);
        hw_frz_o = frz_on_cond_i && en_hit;
        irq_o    = irq_en_i && en_hit;
        soft_frz = freeze_all_i
                 || (priv_i  && frz_super_i)
                 || (!priv_i && frz_user_i)
                 || (mark_i  && frz_mark1_i)
                 || (!mark_i && frz_mark0_i);
        freeze_o = soft_frz || hw_frz_o;
    end

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [REG_W-1:0]          wdata_i,
    output logic [REG_W-1:0]          rdata_o,
    input  logic [NUM_CTR*EV_N-1:0]   ev_i,
    input  logic                      priv_i,
    input  logic                      mark_i,
    output logic                      irq_o
);

    localparam bit HAS_CTL2 = NUM_CTR > 4;

    ctl0_t             ctl0_q;
    logic [REG_W-1:0]  ctl1_q;
    logic [REG_W-1:0]  ctl2_q;
    logic [REG_W-1:0]  cnt_q [NUM_CTR];
    logic [NUM_CTR-1:0] cond;
    logic              freeze;
    logic              hw_frz;
    logic              wr_c0;

    assign wr_c0 = wr_en_i && (addr_i == A_CTL0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl0_q <= ctl0_t'(CTL0_RST);
            ctl1_q <= '0;
        end else begin
            if (wr_c0) begin
                ctl0_q <= ctl0_t'(wdata_i & CTL0_MASK);
            end else if (hw_frz) begin
                ctl0_q.freeze_all <= 1'b1;
            end
            if (wr_en_i && addr_i == A_CTL1) begin
                ctl1_q <= wdata_i;
            end
        end
    end

    generate
        if (HAS_CTL2) begin : g_ctl2
            always_ff @(posedge clk) begin
                if (rst) begin
                    ctl2_q <= '0;
                end else if (wr_en_i && addr_i == A_CTL2) begin
                    ctl2_q <= wdata_i;
                end
            end
        end else begin : g_no_ctl2
            assign ctl2_q = '0;
        end
    endgenerate

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_cnt
            logic ld;
            assign ld = wr_en_i && (addr_i == ADDR_W'(A_CNT0 + i));
            pmu_counter u_cnt (
                .clk      (clk),
                .rst      (rst),
                .ld_i     (ld),
                .ld_val_i (wdata_i),
                .sel_i    (sel_of(i, ctl0_q, ctl1_q)),
                .ev_i     (ev_i[i*EV_N +: EV_N]),
                .frz_i    (freeze),
                .val_o    (cnt_q[i])
            );
            assign cond[i] = cnt_q[i][REG_W-1];
        end
    endgenerate

    pmu_gate #(.NUM_CTR(NUM_CTR)) u_gate (
        .cond_i        (cond),
        .freeze_all_i  (ctl0_q.freeze_all),
        .frz_super_i   (ctl0_q.frz_super),
        .frz_user_i    (ctl0_q.frz_user),
        .frz_mark1_i   (ctl0_q.frz_mark1),
        .frz_mark0_i   (ctl0_q.frz_mark0),
        .frz_on_cond_i (ctl0_q.frz_on_cond),
        .irq_en_i      (ctl0_q.irq_en),
        .ce_first_i    (ctl0_q.cond_en_first),
        .ce_rest_i     (ctl0_q.cond_en_rest),
        .priv_i        (priv_i),
        .mark_i        (mark_i),
        .freeze_o      (freeze),
        .hw_frz_o      (hw_frz),
        .irq_o         (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTL0) begin
            rdata_o = ctl0_q;
        end else if (addr_i == A_CTL1) begin
            rdata_o = ctl1_q;
        end else if (addr_i == A_CTL2) begin
            rdata_o = ctl2_q;
        end else begin
            for (int i = 0; i < NUM_CTR; i++) begin
                if (addr_i == ADDR_W'(A_CNT0 + i)) begin
                    rdata_o = cnt_q[i];
                end
            end
        end
    end

    AST_HW_FREEZE_SETS: assert property (@(posedge clk) disable iff (rst)
        (hw_frz && !wr_c0) |=> ctl0_q.freeze_all); // R7

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq_o && hw_frz && !wr_en_i) |=> irq_o); // R6

    AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ctl0_q.irq_en && cond != '0)); // R6

endmodule

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb;
    import pmu_pkg::*;

    localparam int N = 6;

    localparam logic [31:0] FA  = 32'h8000_0000;
    localparam logic [31:0] FS  = 32'h4000_0000;
    localparam logic [31:0] FU  = 32'h2000_0000;
    localparam logic [31:0] FM1 = 32'h1000_0000;
    localparam logic [31:0] FM0 = 32'h0800_0000;
    localparam logic [31:0] FOC = 32'h0400_0000;
    localparam logic [31:0] IE  = 32'h0200_0000;
    localparam logic [31:0] CE1 = 32'h0100_0000;
    localparam logic [31:0] CEN = 32'h0080_0000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [3:0]         addr = '0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic [N*32-1:0]    ev = '0;
    logic               priv = 1'b0;
    logic               mark = 1'b0;
    logic               irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #5 clk = ~clk;

    perf_mon_unit #(.NUM_CTR(N)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .ev_i    (ev),
        .priv_i  (priv),
        .mark_i  (mark),
        .irq_o   (irq)
    );

    function automatic logic [31:0] s1(input int v); return 32'(v) << 6;  endfunction
    function automatic logic [31:0] s2(input int v); return 32'(v);       endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'd0, irq} : rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic exp_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #1 -> chk_ev;
        #1;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        #1 -> chk_ev;
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ev(input int ctr, input int b, input logic v);
        ev[ctr*32 + b] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        exp_reg(4'd0, 32'hF800_0000, "R1 ctl0 reset");
        exp_reg(4'd1, 32'h0, "R1 ctl1 reset");
        exp_reg(4'd2, 32'h0, "R1 ctl2 reset");
        exp_reg(4'd3, 32'h0, "R1 cnt1 reset");
        exp_reg(4'd8, 32'h0, "R1 cnt6 reset");
        exp_irq(1'b0, "R1 irq reset");

        // R3/R4 basic counting, select 0 holds
        wr(4'd1, 32'(3) << 27);
        wr(4'd0, s1(1) | s2(2));
        @(negedge clk);
        set_ev(0, 1, 1); set_ev(1, 5, 1); set_ev(2, 3, 1); set_ev(3, 0, 1);
        run(10);
        ev = '0;
        exp_reg(4'd3, 32'd10, "R3 cnt1 counts selected line");
        exp_reg(4'd4, 32'd0,  "R3 cnt2 ignores unselected line");
        exp_reg(4'd5, 32'd10, "R4 cnt3 select at ctl1[31:27]");
        exp_reg(4'd6, 32'd0,  "R3 cnt4 select 0 holds");

        // R5 freeze by privilege
        wr(4'd0, FS | s1(1));
        priv = 1'b1; set_ev(0, 1, 1);
        run(5);
        exp_reg(4'd3, 32'd10, "R5 supervisor freeze");
        priv = 1'b0;
        run(5);
        ev = '0;
        exp_reg(4'd3, 32'd15, "R5 counts in user state");
        wr(4'd0, FU | s1(1));
        set_ev(0, 1, 1); run(2); ev = '0;
        exp_reg(4'd3, 32'd15, "R5 user freeze");

        // R5 freeze by mark
        wr(4'd0, FM0 | s1(1));
        mark = 1'b0; set_ev(0, 1, 1); run(3);
        exp_reg(4'd3, 32'd15, "R5 mark0 freeze");
        mark = 1'b1; run(3); ev = '0;
        exp_reg(4'd3, 32'd18, "R5 counts with mark 1");
        wr(4'd0, FM1 | s1(1));
        set_ev(0, 1, 1); run(3); ev = '0;
        exp_reg(4'd3, 32'd18, "R5 mark1 freeze");
        mark = 1'b0;
        wr(4'd0, FA | s1(1));
        set_ev(0, 1, 1); run(3); ev = '0;
        exp_reg(4'd3, 32'd18, "R5 freeze all");

        // R8 write beats increment
        wr(4'd0, s1(1));
        @(negedge clk);
        set_ev(0, 1, 1); wr_en = 1'b1; addr = 4'd3; wdata = 32'd100;
        @(negedge clk);
        ev = '0; wr_en = 1'b0;
        exp_reg(4'd3, 32'd100, "R8 write over increment");

        // R6 counter 1 condition and level irq
        wr(4'd0, IE | CE1 | s1(1));
        wr(4'd3, 32'h7FFF_FFFD);
        set_ev(0, 1, 1); run(2); ev = '0;
        exp_reg(4'd3, 32'h7FFF_FFFF, "R6 before boundary");
        exp_irq(1'b0, "R6 no irq before boundary");
        set_ev(0, 1, 1); run(1); ev = '0;
        exp_reg(4'd3, 32'h8000_0000, "R6 boundary reached");
        exp_irq(1'b1, "R6 irq on condition");
        run(3);
        exp_irq(1'b1, "R6 irq level held");
        wr(4'd3, 32'd0);
        exp_irq(1'b0, "R6 irq cleared by rewrite");

        // R6 shared enable for counters 2..6
        wr(4'd0, IE | CEN | s2(2));
        wr(4'd4, 32'h8000_0000);
        exp_irq(1'b1, "R6 shared enable irq");
        wr(4'd0, IE | s2(2));
        exp_irq(1'b0, "R6 shared enable off");
        wr(4'd4, 32'd0);

        // R7 hardware freeze on enabled condition
        wr(4'd0, FOC | CE1 | s1(1) | s2(2));
        wr(4'd3, 32'h7FFF_FFFE);
        @(negedge clk);
        set_ev(0, 1, 1); set_ev(1, 2, 1);
        run(5);
        ev = '0;
        exp_reg(4'd3, 32'h8000_0000, "R7 cnt1 stopped at boundary");
        exp_reg(4'd4, 32'd2, "R7 cnt2 stopped same cycle");
        exp_reg(4'd0, FA | FOC | CE1 | s1(1) | s2(2), "R7 freeze bit set by hw");
        exp_irq(1'b0, "R6 irq needs enable");
        wr(4'd3, 32'd0);
        wr(4'd4, 32'd0);

        // R9 wrap
        wr(4'd0, s1(1));
        wr(4'd3, 32'hFFFF_FFFF);
        set_ev(0, 1, 1); run(1); ev = '0;
        exp_reg(4'd3, 32'd0, "R9 wrap to zero");

        // R4 counters 5 and 6 select positions
        wr(4'd1, (32'(7) << 17) | (32'(31) << 11));
        set_ev(4, 7, 1); set_ev(5, 31, 1); set_ev(2, 3, 1);
        run(4);
        ev = '0;
        exp_reg(4'd7, 32'd4, "R4 cnt5 select at ctl1[21:17]");
        exp_reg(4'd8, 32'd4, "R4 cnt6 select at ctl1[15:11]");
        exp_reg(4'd5, 32'd10, "R4 cnt3 select cleared holds");

        // R2 register map
        wr(4'd2, 32'h1234_5678);
        exp_reg(4'd2, 32'h1234_5678, "R2 spare register storage");
        exp_reg(4'd1, (32'(7) << 17) | (32'(31) << 11), "R2 ctl1 readback");
        wr(4'd9, 32'hFFFF_FFFF);
        exp_reg(4'd9, 32'd0, "R2 unmapped address reads 0");
        exp_reg(4'd0, s1(1), "R2 unmapped write no effect");
        wr(4'd0, 32'hFFFF_FFFF);
        exp_reg(4'd0, 32'hFF80_07DF, "R2 ctl0 write mask");

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule